// File: doc/BRIEF.md
# Programmable Duty-Cycle Oscillator

This block produces a free-running clock whose high and low times are set in whole clock ticks. It has two timing stages joined in a ring through an inverter. A hold-off stage rises with its input and stays high for a programmed number of ticks after the input drops. A delay-on stage rises only once its input has stayed high for a programmed number of ticks, and it drops as soon as the input drops. The period is the sum of the two settings, and their ratio sets the duty cycle. Equal settings give 50%. Settings of 1 and 3 give 25%/75%.

The ring's inverter drives one register, so the loop is never purely combinational. Each ring stage is loaded with its setting minus one, which keeps the period at exactly the sum of the settings. Both stages can also be instantiated as standalone modules. The parameter `ORDER` picks the stage order inside the ring. `ORDER=0` places hold-off first, and its inter-stage tap gives a one-tick low pulse. `ORDER=1` places delay-on first, and its tap gives a one-tick high pulse.

Ticks are counted from the first cycle after the clock edge at which a period starts (tick 0). `H` and `L` are the effective high and low settings.

Top module: `duty_osc`

## Requirements
- R1: The standalone hold-off stage (`osc_hold_stage`) drives its output high in the same cycle its input is high. After the input goes low, the output stays high for exactly `dly` further cycles and then goes low.
- R2: The standalone delay-on stage (`osc_delay_stage`) drives its output high only in a cycle where its input has been high for more than `dly` consecutive cycles, counting the current one. The output is low in any cycle where the input is low.
- R3: A standalone stage with `dly` = 0 is transparent: its output equals its input in every cycle.
- R4: While `en` stays high and the settings are unchanged, `clkMain` is high on ticks L-1 through L+H-2 of each period. It is low on the other ticks, and the period is H+L ticks. Here H = `highTicks` and L = `lowTicks`. `clkMain` never rises unless `en` was high in the previous cycle.
- R5: `clkInv` is always the complement of `clkMain`. So it is high for L ticks per period, and it is high while the block is disabled.
- R6: With `ORDER=0`, `tapOut` is low only on the last tick (H+L-1) of each period, and each low pulse lasts one tick. With `ORDER=1`, `tapOut` is high only on tick L-1, and each high pulse lasts one tick.
- R7: In the oscillator, a setting of 0 is treated as 1, so the period is never shorter than 2 ticks.
- R8: In the cycle after `en` is sampled low, `clkMain` and `tapOut` are low and every stage is cleared. When `en` is sampled high again, a fresh period starts at tick 0 on the next cycle.
- R9: `highTicks` and `lowTicks` are sampled only at the clock edge that starts a period. A change made during a running period takes effect at the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the ring cleared |
| highTicks | input | W | Hold-off setting; ticks `clkMain` is high per period |
| lowTicks | input | W | Delay-on setting; ticks `clkMain` is low per period |
| clkMain | output | 1 | Main clock phase |
| clkInv | output | 1 | Complementary clock phase |
| tapOut | output | 1 | Inter-stage tap; one-tick pulse each period |

## Verification
The assertions check on every cycle that the tap pulse is one tick wide and has the correct polarity for the chosen order. They also check that the tap and `clkMain` never contradict each other, that both are low one cycle after `en` drops, and that `clkMain` rises only while enabled. The exact tick positions of each phase, the clamping of zero settings and the deferral of setting changes to the next period depend on history across a whole period. Only the bench's cycle-by-cycle model can show these. The same applies to the standalone stages' hold and delay counts.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef struct packed {
    logic clr;   // hold every stage and the ring register cleared
    logic load;  // capture new settings; a period starts at this edge
  } oscStrobe_t;
endpackage

// File: rtl/osc_hold_stage.sv
module osc_hold_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] dly,
  input  logic         sigIn,
  output logic         sigOut
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)        remain <= '0;
    else if (sigIn)           remain <= dly;
    else if (remain != '0)    remain <= remain - W'(1);
  end

  assign sigOut = sigIn | (remain != '0);
endmodule

// File: rtl/osc_delay_stage.sv
module osc_delay_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] dly,
  input  logic         sigIn,
  output logic         sigOut
);
  logic [W-1:0] heldFor;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !sigIn) heldFor <= '0;
    else if (heldFor < dly)      heldFor <= heldFor + W'(1);
  end

  assign sigOut = sigIn & (heldFor >= dly);
endmodule

// File: rtl/osc_control.sv
module osc_control
  import osc_pkg::*;
(
  input  logic       en,
  input  logic       ringQ,
  input  logic       lastOut,
  output oscStrobe_t stb
);
  always_comb begin
    stb.clr  = !en;
    // ring register about to rise: both ends of the loop are low
    stb.load = en && !ringQ && !lastOut;
  end
endmodule

// File: rtl/osc_datapath.sv
module osc_datapath
  import osc_pkg::*;
#(
  parameter int W     = 4,
  parameter int ORDER = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  oscStrobe_t   stb,
  input  logic [W-1:0] highTicks,
  input  logic [W-1:0] lowTicks,
  output logic         ringQ,
  output logic         lastOut,
  output logic         tapOut,
  output logic         clkMain,
  output logic         clkInv
);
  logic [W-1:0] holdAct, delayAct;
  logic         firstOut, secondOut;

  // the ring register adds one tick per half cycle, so stages run one short;
  // a zero setting clamps to one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdAct  <= '0;
      delayAct <= '0;
    end else if (stb.load) begin
      holdAct  <= (highTicks == '0) ? '0 : highTicks - W'(1);
      delayAct <= (lowTicks  == '0) ? '0 : lowTicks  - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clr) ringQ <= 1'b0;
    else                   ringQ <= ~lastOut;
  end

  generate
    if (ORDER == 0) begin : g_holdFirst
      osc_hold_stage  #(.W(W)) u_first  (.clk(clk), .rst_n(rst_n), .clr(stb.clr),
                                         .dly(holdAct), .sigIn(ringQ), .sigOut(firstOut));
      osc_delay_stage #(.W(W)) u_second (.clk(clk), .rst_n(rst_n), .clr(stb.clr),
                                         .dly(delayAct), .sigIn(firstOut), .sigOut(secondOut));
    end else begin : g_delayFirst
      osc_delay_stage #(.W(W)) u_first  (.clk(clk), .rst_n(rst_n), .clr(stb.clr),
                                         .dly(delayAct), .sigIn(ringQ), .sigOut(firstOut));
      osc_hold_stage  #(.W(W)) u_second (.clk(clk), .rst_n(rst_n), .clr(stb.clr),
                                         .dly(holdAct), .sigIn(firstOut), .sigOut(secondOut));
    end
  endgenerate

  assign tapOut  = firstOut;
  assign lastOut = secondOut;
  assign clkMain = secondOut;
  assign clkInv  = ~secondOut;
endmodule

// File: rtl/duty_osc.sv
module duty_osc
  import osc_pkg::*;
#(
  parameter int W     = 4,
  parameter int ORDER = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] highTicks,
  input  logic [W-1:0] lowTicks,
  output logic         clkMain,
  output logic         clkInv,
  output logic         tapOut
);
  oscStrobe_t stb;
  logic       ringQ, lastOut;

  osc_control u_ctrl (.en(en), .ringQ(ringQ), .lastOut(lastOut), .stb(stb));

  osc_datapath #(.W(W), .ORDER(ORDER)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .highTicks(highTicks), .lowTicks(lowTicks),
    .ringQ(ringQ), .lastOut(lastOut),
    .tapOut(tapOut), .clkMain(clkMain), .clkInv(clkInv)
  );
endmodule

// File: rtl/osc_checker.sv
module osc_checker #(
  parameter int ORDER = 0
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic clkMain,
  input logic tapOut
);
  // R8: one cycle after en is low, main clock and tap are low
  p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!clkMain && !tapOut));

  // R4: main clock only rises after an enabled cycle
  p_main_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkMain) |-> $past(en));

  generate
    if (ORDER == 0) begin : g_lowTap
      // R6: low tap pulse lasts a single tick
      p_tap_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tapOut) && en) |=> tapOut);
      // R6: tap low forces the following stage low
      p_tap_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tapOut |-> !clkMain);
    end else begin : g_highTap
      // R6: high tap pulse lasts a single tick
      p_tap_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tapOut) |=> !tapOut);
      // R6: tap high forces the following stage high
      p_tap_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tapOut |-> clkMain);
    end
  endgenerate
endmodule

bind duty_osc osc_checker #(.ORDER(ORDER)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clkMain(clkMain), .tapOut(tapOut)
);

// File: tb/duty_osc_tb.sv
module duty_osc_tb;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] highTicks = '0, lowTicks = '0;
  logic clkMain, clkInv, tapOut;
  logic rMain, rInv, rTap;
  logic holdIn = 1'b0, delayIn = 1'b0, holdOut, delayOut;
  logic [W-1:0] holdDly = '0, delayDly = '0;

  int nChecks = 0, nFail = 0, cyc = 0;

  // oscillator model state
  int ph = -1, qH = 1, qL = 1;
  bit qZero = 0;
  // stage model state
  int lowRun = 1000, highRun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_osc #(.W(W), .ORDER(0)) u_dut (.clk(clk), .rst_n(rst_n), .en(en),
    .highTicks(highTicks), .lowTicks(lowTicks),
    .clkMain(clkMain), .clkInv(clkInv), .tapOut(tapOut));
  duty_osc #(.W(W), .ORDER(1)) u_rev (.clk(clk), .rst_n(rst_n), .en(en),
    .highTicks(highTicks), .lowTicks(lowTicks),
    .clkMain(rMain), .clkInv(rInv), .tapOut(rTap));
  osc_hold_stage  #(.W(W)) u_hold (.clk(clk), .rst_n(rst_n), .clr(1'b0),
    .dly(holdDly), .sigIn(holdIn), .sigOut(holdOut));
  osc_delay_stage #(.W(W)) u_dly  (.clk(clk), .rst_n(rst_n), .clr(1'b0),
    .dly(delayDly), .sigIn(delayIn), .sigOut(delayOut));

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  function automatic int effOf(logic [W-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  function automatic logic expMain();
    return (ph >= 0) && (ph >= qL - 1) && (ph <= qL + qH - 2);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic newStageSeg(logic [W-1:0] hd, logic [W-1:0] dd);
    holdDly = hd; delayDly = dd;
  endtask

  task automatic tick();
    string req;
    bit holdExp, delayExp;
    @(posedge clk);
    if (!en) ph = -1;
    else if (ph == -1 || ph == qH + qL - 1) begin
      qH = effOf(highTicks); qL = effOf(lowTicks);
      qZero = (highTicks == '0) || (lowTicks == '0);
      ph = 0;
    end else ph++;
    @(negedge clk);
    if (ph == -1) req = "R8";
    else if (effOf(highTicks) != qH || effOf(lowTicks) != qL) req = "R9";
    else if (qZero) req = "R7";
    else req = "R4";
    chk(req, "clkMain", clkMain, expMain());
    chk(req, "rev clkMain", rMain, expMain());
    chk("R5", "clkInv", clkInv, !expMain());
    chk("R5", "rev clkInv", rInv, !expMain());
    chk("R6", "tap order0", tapOut, (ph >= 0) && (ph != qH + qL - 1));
    chk("R6", "tap order1", rTap, (ph >= 0) && (ph == qL - 1));
    // standalone stages: new inputs after the edge
    holdIn  = ($urandom % 4) == 0;
    delayIn = ($urandom % 4) != 0;
    lowRun  = holdIn ? 0 : lowRun + 1;
    highRun = delayIn ? highRun + 1 : 0;
    #1;
    holdExp  = holdIn || (lowRun >= 1 && lowRun <= int'(holdDly));
    delayExp = delayIn && (highRun > int'(delayDly));
    chk((holdDly == '0) ? "R3" : "R1", "hold stage", holdOut, holdExp);
    chk((delayDly == '0) ? "R3" : "R2", "delay stage", delayOut, delayExp);
  endtask

  task automatic runSeg(int h, int l, int n);
    highTicks = W'(h); lowTicks = W'(l); en = 1'b1;
    holdIn = 1'b1; delayIn = 1'b0; lowRun = 0; highRun = 0;
    newStageSeg(W'(h), W'(l));
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset clkMain", clkMain, 1'b0);
    chk("R5", "reset clkInv", clkInv, 1'b1);
    chk("R6", "reset tap", tapOut, 1'b0);
    rst_n = 1'b1;
    tick(); tick();
    // directed cases: duty ratios, transparency, clamping
    runSeg(3, 1, 24);
    runSeg(1, 3, 24);
    runSeg(2, 2, 24);
    runSeg(1, 1, 12);
    runSeg(0, 0, 12);   // R7 clamp, R3 transparent stages
    runSeg(0, 4, 20);
    runSeg(7, 0, 24);
    runSeg(15, 15, 64);
    // R8: disable mid-period and restart
    en = 1'b0; tick(); tick(); tick();
    runSeg(5, 2, 30);
    // R9: settings changed inside running periods
    for (int i = 0; i < 20; i++) begin
      tick(); tick();
      highTicks = W'($urandom % 6);
      lowTicks  = W'($urandom % 6);
      for (int k = 0; k < 9; k++) tick();
    end
    // random mix
    for (int s = 0; s < 60; s++) begin
      runSeg($urandom % 16, $urandom % 16, 10 + ($urandom % 40));
      if (($urandom % 3) == 0) begin
        en = 1'b0;
        for (int k = 0; k < 1 + ($urandom % 3); k++) tick();
      end
    end
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule